// File: doc/BRIEF.md
# Bank Reference Queue with Row Arbiter and Precharge Manager

This block holds the memory references that target one DRAM bank while they wait for service. Loads and stores enter through a ready/valid port and are written into the lowest-numbered free slot. Each slot keeps its load/store flag, row, column, write data, an arrival rank and a flag that says whether its row is the one currently open in the bank.

From this state the block chooses its own bank operations. The row arbiter proposes an activate for the row of the oldest waiting reference whenever the bank has no open row. The precharge manager proposes closing the open row once no waiting reference hits it and some reference needs another row. The block also exposes a mask of slots that hit the open row, for a shared column arbiter. When that arbiter grants a slot, the block retires it and shows the slot's fields on the grant outputs in the same cycle. DRAM timing is handled outside the block and arrives as the `act_ready` and `pre_ready` accept inputs.

Top module: `bank_ref_queue`

## Requirements
- R1: After reset the queue is empty, `req_ready` is 1, `act_valid`, `pre_valid` and `open_valid` are 0 and `hit_mask` is all zero.
- R2: A reference offered while `req_ready` is 1 is stored in the lowest-numbered free slot. `req_ready` is 0 exactly when all DEPTH slots are occupied, and a reference offered while it is 0 is not stored.
- R3: While no row is open and at least one slot is occupied, `act_valid` is 1 and `act_row` equals the row of the earliest-arrived occupied slot. Otherwise `act_valid` is 0.
- R4: In the cycle after an activate is accepted (`act_valid` and `act_ready` both 1), `open_valid` is 1, `open_row` equals the activated row, and `hit_mask` bit i is 1 exactly for the occupied slots i that hold that row.
- R5: A reference stored while a row is open has its `hit_mask` bit set from the next cycle when its row equals `open_row`.
- R6: `pre_valid` is 1 exactly when a row is open, no occupied slot hits it, and at least one slot is occupied. An open row with an empty queue stays open.
- R7: In the cycle after a precharge is accepted (`pre_valid` and `pre_ready` both 1), `open_valid` is 0 and `hit_mask` is zero.
- R8: With `col_grant` at 1, the grant outputs show the store flag, column and write data of slot `col_grant_idx` in the same cycle. The slot is freed at the next edge if its `hit_mask` bit is 1. A grant to a slot whose bit is 0 changes nothing.
- R9: Arrival order survives retirements and refills. A reference stored into a slot freed earlier is younger than every reference already waiting.
- R10: `act_valid` and `pre_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming reference offered |
| req_ready | output | 1 | A free slot exists |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Store data |
| act_valid | output | 1 | Activate proposed |
| act_row | output | ROW_W | Row to activate |
| act_ready | input | 1 | Activate accepted this cycle |
| pre_valid | output | 1 | Precharge proposed |
| pre_ready | input | 1 | Precharge accepted this cycle |
| open_valid | output | 1 | A row is open in the bank |
| open_row | output | ROW_W | The open row |
| hit_mask | output | DEPTH | Occupied slots hitting the open row |
| col_grant | input | 1 | Column arbiter grant |
| col_grant_idx | input | IDX_W | Granted slot |
| gnt_is_store | output | 1 | Store flag of the granted slot |
| gnt_col | output | COL_W | Column of the granted slot |
| gnt_wdata | output | DATA_W | Write data of the granted slot |

## Verification
The assertions take for granted that the accept inputs are only meaningful while the matching proposal is up, and that the column arbiter names a slot index below DEPTH. The stimulus raises `act_ready` or `pre_ready` only in cycles where the expected proposal is known to be present. It issues grants to hitting slots, plus one deliberate grant to a non-hitting slot. It offers one reference while the queue is full so that the back-pressure path is exercised without breaking these assumptions.

// File: rtl/bank_ref_pkg.sv
package bank_ref_pkg;

   typedef enum logic {
      BANK_IDLE = 1'b0,
      BANK_OPEN = 1'b1
   } bank_state_e;

   function automatic int unsigned rank_width(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/bank_ref_slots.sv
module bank_ref_slots #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ROW_W  = 14,
   parameter int unsigned COL_W  = 10,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = bank_ref_pkg::rank_width(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_en,
   input  logic              ins_store,
   input  logic [ROW_W-1:0]  ins_row,
   input  logic [COL_W-1:0]  ins_col,
   input  logic [DATA_W-1:0] ins_data,
   input  logic              ret_en,
   input  logic [IDX_W-1:0]  ret_idx,
   input  logic              act_fire,
   input  logic [ROW_W-1:0]  act_row,
   input  logic              pre_fire,
   input  logic              open_valid,
   input  logic [ROW_W-1:0]  open_row,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DEPTH-1:0]  valid_q,
   output logic [DEPTH-1:0]  hit_q,
   output logic [IDX_W-1:0]  rank_q [DEPTH],
   output logic [ROW_W-1:0]  row_q  [DEPTH],
   output logic [IDX_W-1:0]  free_idx,
   output logic              full,
   output logic              rd_store,
   output logic [COL_W-1:0]  rd_col,
   output logic [DATA_W-1:0] rd_data
);

   logic [DEPTH-1:0]  store_q;
   logic [COL_W-1:0]  col_q  [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [CNT_W-1:0]  occ_cnt;
   logic [IDX_W-1:0]  new_rank;
   logic [IDX_W-1:0]  ret_rank;

   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_q[i]) free_idx = IDX_W'(i);
      end
   end

   assign full     = &valid_q;
   assign occ_cnt  = CNT_W'($countones(valid_q));
   assign new_rank = IDX_W'(occ_cnt - CNT_W'(ret_en));
   assign ret_rank = rank_q[ret_idx];
   assign rd_store = store_q[rd_idx];
   assign rd_col   = col_q[rd_idx];
   assign rd_data  = data_q[rd_idx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic here_ins;
      logic here_ret;
      assign here_ins = ins_en && (free_idx == IDX_W'(g));
      assign here_ret = ret_en && (ret_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            hit_q[g]   <= 1'b0;
            store_q[g] <= 1'b0;
            rank_q[g]  <= '0;
            row_q[g]   <= '0;
            col_q[g]   <= '0;
            data_q[g]  <= '0;
         end else begin
            if (here_ins) begin
               valid_q[g] <= 1'b1;
               store_q[g] <= ins_store;
               row_q[g]   <= ins_row;
               col_q[g]   <= ins_col;
               data_q[g]  <= ins_data;
               rank_q[g]  <= new_rank;
            end else if (here_ret) begin
               valid_q[g] <= 1'b0;
            end else if (valid_q[g] && ret_en && (rank_q[g] > ret_rank)) begin
               rank_q[g]  <= rank_q[g] - 1'b1;
            end

            if (pre_fire) begin
               hit_q[g] <= 1'b0;
            end else if (act_fire) begin
               hit_q[g] <= here_ins ? (ins_row == act_row) : (row_q[g] == act_row);
            end else if (here_ins) begin
               hit_q[g] <= open_valid && (ins_row == open_row);
            end
         end
      end
   end

   // R2: a store never lands when no slot was free
   a_r2_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !ret_en) |=> (&valid_q));
   // R8: a retired slot is empty afterwards (refill goes to a slot free before the edge)
   a_r8_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && !full) |=> !valid_q[$past(ret_idx)]);

endmodule

// File: rtl/bank_row_pick.sv
module bank_row_pick #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned ROW_W = 14,
   localparam int unsigned IDX_W = bank_ref_pkg::rank_width(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] valid_q,
   input  logic [IDX_W-1:0] rank_q [DEPTH],
   input  logic [ROW_W-1:0] row_q  [DEPTH],
   input  logic             bank_open,
   output logic             act_valid,
   output logic [ROW_W-1:0] act_row
);

   logic [DEPTH-1:0] oldest_mask;

   for (genvar g = 0; g < DEPTH; g++) begin : g_old
      assign oldest_mask[g] = valid_q[g] && (rank_q[g] == '0);
   end

   always_comb begin
      act_row = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (oldest_mask[i]) act_row = row_q[i];
      end
   end

   assign act_valid = !bank_open && (|valid_q);

   // R9: arrival ranks name a single oldest slot
   a_r9_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(oldest_mask));
   // R9: any occupied queue has an oldest slot
   a_r9_oldest_exists: assert property (@(posedge clk) disable iff (!rst_n)
      (|valid_q) |-> (|oldest_mask));

endmodule

// File: rtl/bank_close_ctl.sv
module bank_close_ctl #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned ROW_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] valid_q,
   input  logic [DEPTH-1:0] hit_q,
   input  logic             act_fire,
   input  logic [ROW_W-1:0] act_row,
   input  logic             pre_fire,
   output logic             bank_open,
   output logic [ROW_W-1:0] open_row,
   output logic             pre_valid
);
   import bank_ref_pkg::*;

   bank_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= BANK_IDLE;
         open_row <= '0;
      end else if (pre_fire) begin
         state_q  <= BANK_IDLE;
      end else if (act_fire) begin
         state_q  <= BANK_OPEN;
         open_row <= act_row;
      end
   end

   assign bank_open = (state_q == BANK_OPEN);
   assign pre_valid = bank_open && (|valid_q) && !(|(valid_q & hit_q));

   // R4: an accepted activate opens its row
   a_r4_open_after_act: assert property (@(posedge clk) disable iff (!rst_n)
      (act_fire && !pre_fire) |=> (bank_open && open_row == $past(act_row)));
   // R7: an accepted precharge closes the bank
   a_r7_closed_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      pre_fire |=> !bank_open);

endmodule

// File: rtl/bank_ref_queue.sv
module bank_ref_queue #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ROW_W  = 14,
   parameter int unsigned COL_W  = 10,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = bank_ref_pkg::rank_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_store,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              act_valid,
   output logic [ROW_W-1:0]  act_row,
   input  logic              act_ready,
   output logic              pre_valid,
   input  logic              pre_ready,
   output logic              open_valid,
   output logic [ROW_W-1:0]  open_row,
   output logic [DEPTH-1:0]  hit_mask,
   input  logic              col_grant,
   input  logic [IDX_W-1:0]  col_grant_idx,
   output logic              gnt_is_store,
   output logic [COL_W-1:0]  gnt_col,
   output logic [DATA_W-1:0] gnt_wdata
);

   if (DEPTH < 2)  $error("bank_ref_queue: DEPTH must be at least 2");
   if (ROW_W < 1)  $error("bank_ref_queue: ROW_W must be positive");
   if (COL_W < 1)  $error("bank_ref_queue: COL_W must be positive");
   if (DATA_W < 1) $error("bank_ref_queue: DATA_W must be positive");

   logic [DEPTH-1:0] valid_q;
   logic [DEPTH-1:0] hit_q;
   logic [IDX_W-1:0] rank_q [DEPTH];
   logic [ROW_W-1:0] row_q  [DEPTH];
   logic [IDX_W-1:0] free_idx;
   logic             full;
   logic             ins_en;
   logic             ret_en;
   logic             act_fire;
   logic             pre_fire;

   assign req_ready = !full;
   assign ins_en    = req_valid && !full;
   assign act_fire  = act_valid && act_ready;
   assign pre_fire  = pre_valid && pre_ready;
   assign hit_mask  = valid_q & hit_q;
   assign ret_en    = col_grant && hit_mask[col_grant_idx];

   bank_ref_slots #(
      .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
   ) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_en     (ins_en),
      .ins_store  (req_is_store),
      .ins_row    (req_row),
      .ins_col    (req_col),
      .ins_data   (req_wdata),
      .ret_en     (ret_en),
      .ret_idx    (col_grant_idx),
      .act_fire   (act_fire),
      .act_row    (act_row),
      .pre_fire   (pre_fire),
      .open_valid (open_valid),
      .open_row   (open_row),
      .rd_idx     (col_grant_idx),
      .valid_q    (valid_q),
      .hit_q      (hit_q),
      .rank_q     (rank_q),
      .row_q      (row_q),
      .free_idx   (free_idx),
      .full       (full),
      .rd_store   (gnt_is_store),
      .rd_col     (gnt_col),
      .rd_data    (gnt_wdata)
   );

   bank_row_pick #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_q   (valid_q),
      .rank_q    (rank_q),
      .row_q     (row_q),
      .bank_open (open_valid),
      .act_valid (act_valid),
      .act_row   (act_row)
   );

   bank_close_ctl #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_close (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_q   (valid_q),
      .hit_q     (hit_q),
      .act_fire  (act_fire),
      .act_row   (act_row),
      .pre_fire  (pre_fire),
      .bank_open (open_valid),
      .open_row  (open_row),
      .pre_valid (pre_valid)
   );

   // R10: activate and precharge proposals exclude each other
   a_r10_act_pre_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_valid && pre_valid));
   // R6: a precharge is only proposed when nothing hits the open row
   a_r6_pre_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      pre_valid |-> (hit_mask == '0));
   // R7: with the bank closed nothing is marked as a hit
   a_r7_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !open_valid |-> (hit_mask == '0));
   // R8: a grant to a non-hitting slot leaves the occupancy unchanged
   a_r8_ignored_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (col_grant && !hit_mask[col_grant_idx] && !req_valid) |=> $stable(req_ready));

endmodule

// File: tb/bank_ref_queue_bench.sv
module bank_ref_queue_bench;
   localparam int unsigned DEPTH  = 8;
   localparam int unsigned ROW_W  = 14;
   localparam int unsigned COL_W  = 10;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned IDX_W  = 3;

   typedef enum logic [2:0] {OP_IDLE, OP_INS, OP_ACT, OP_PRE, OP_GNT} op_e;

   typedef struct packed {
      op_e              op;
      logic [ROW_W-1:0] row;
      logic [COL_W-1:0] col;
      logic [IDX_W-1:0] idx;
      logic             e_act;
      logic [ROW_W-1:0] e_row;
      logic             e_pre;
      logic             e_open;
      logic [DEPTH-1:0] e_hit;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VEC [NVEC] = '{
      '{OP_INS, 14'd5, 10'd1, 3'd0, 1'b1, 14'd5, 1'b0, 1'b0, 8'h00},
      '{OP_INS, 14'd7, 10'd2, 3'd0, 1'b1, 14'd5, 1'b0, 1'b0, 8'h00},
      '{OP_INS, 14'd5, 10'd3, 3'd0, 1'b1, 14'd5, 1'b0, 1'b0, 8'h00},
      '{OP_ACT, 14'd0, 10'd0, 3'd0, 1'b0, 14'd5, 1'b0, 1'b1, 8'h05},
      '{OP_INS, 14'd5, 10'd4, 3'd0, 1'b0, 14'd5, 1'b0, 1'b1, 8'h0D},
      '{OP_GNT, 14'd0, 10'd0, 3'd0, 1'b0, 14'd5, 1'b0, 1'b1, 8'h0C},
      '{OP_GNT, 14'd0, 10'd0, 3'd1, 1'b0, 14'd7, 1'b0, 1'b1, 8'h0C},
      '{OP_GNT, 14'd0, 10'd0, 3'd2, 1'b0, 14'd7, 1'b0, 1'b1, 8'h08},
      '{OP_GNT, 14'd0, 10'd0, 3'd3, 1'b0, 14'd7, 1'b1, 1'b1, 8'h00},
      '{OP_PRE, 14'd0, 10'd0, 3'd0, 1'b1, 14'd7, 1'b0, 1'b0, 8'h00},
      '{OP_ACT, 14'd0, 10'd0, 3'd0, 1'b0, 14'd7, 1'b0, 1'b1, 8'h02},
      '{OP_GNT, 14'd0, 10'd0, 3'd1, 1'b0, 14'd7, 1'b0, 1'b1, 8'h00}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_is_store = 1'b0;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              act_valid;
   logic [ROW_W-1:0]  act_row;
   logic              act_ready = 1'b0;
   logic              pre_valid;
   logic              pre_ready = 1'b0;
   logic              open_valid;
   logic [ROW_W-1:0]  open_row;
   logic [DEPTH-1:0]  hit_mask;
   logic              col_grant = 1'b0;
   logic [IDX_W-1:0]  col_grant_idx = '0;
   logic              gnt_is_store;
   logic [COL_W-1:0]  gnt_col;
   logic [DATA_W-1:0] gnt_wdata;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bank_ref_queue #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_bank_ref_queue (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_is_store(req_is_store),
      .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
      .act_valid(act_valid), .act_row(act_row), .act_ready(act_ready),
      .pre_valid(pre_valid), .pre_ready(pre_ready),
      .open_valid(open_valid), .open_row(open_row), .hit_mask(hit_mask),
      .col_grant(col_grant), .col_grant_idx(col_grant_idx),
      .gnt_is_store(gnt_is_store), .gnt_col(gnt_col), .gnt_wdata(gnt_wdata)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one operation: drive at negedge, clock it in, return at next negedge
   task automatic step(input op_e op, input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                       input logic st, input logic [DATA_W-1:0] data, input logic [IDX_W-1:0] idx);
      req_valid     = (op == OP_INS);
      req_row       = row;
      req_col       = col;
      req_is_store  = st;
      req_wdata     = data;
      act_ready     = (op == OP_ACT);
      pre_ready     = (op == OP_PRE);
      col_grant     = (op == OP_GNT);
      col_grant_idx = idx;
      @(posedge clk);
      #1;
      req_valid = 1'b0; act_ready = 1'b0; pre_ready = 1'b0; col_grant = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_reset_state();
      chk("R1 req_ready", 64'(req_ready), 64'd1);
      chk("R1 act_valid", 64'(act_valid), 64'd0);
      chk("R1 pre_valid", 64'(pre_valid), 64'd0);
      chk("R1 open_valid", 64'(open_valid), 64'd0);
      chk("R1 hit_mask", 64'(hit_mask), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state();

      // table walk: R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         if (VEC[v].op == OP_GNT && v == 5) begin
            col_grant = 1'b1; col_grant_idx = VEC[v].idx;
            #1;
            chk("R8 gnt_is_store", 64'(gnt_is_store), 64'd1);
            chk("R8 gnt_col", 64'(gnt_col), 64'd1);
            chk("R8 gnt_wdata", 64'(gnt_wdata), 64'h0000_00AA);
         end
         step(VEC[v].op, VEC[v].row, VEC[v].col, (v == 0), (v == 0) ? 32'hAA : 32'h0, VEC[v].idx);
         chk($sformatf("R3 act_valid v%0d", v), 64'(act_valid), 64'(VEC[v].e_act));
         if (VEC[v].e_act) chk($sformatf("R3 act_row v%0d", v), 64'(act_row), 64'(VEC[v].e_row));
         chk($sformatf("R6 pre_valid v%0d", v), 64'(pre_valid), 64'(VEC[v].e_pre));
         chk($sformatf("R4 R7 open_valid v%0d", v), 64'(open_valid), 64'(VEC[v].e_open));
         chk($sformatf("R4 R5 R8 hit_mask v%0d", v), 64'(hit_mask), 64'(VEC[v].e_hit));
         chk($sformatf("R10 exclusive v%0d", v), 64'(act_valid & pre_valid), 64'd0);
      end
      chk("R6 empty queue keeps row open", 64'(open_row), 64'd7);

      // R2: fill every slot, rows 10..17
      for (int k = 0; k < DEPTH; k++) begin
         chk("R2 ready before full", 64'(req_ready), 64'd1);
         step(OP_INS, ROW_W'(10 + k), COL_W'(k), 1'b0, 32'h0, '0);
      end
      chk("R2 ready low when full", 64'(req_ready), 64'd0);
      chk("R6 pre when no hit", 64'(pre_valid), 64'd1);
      // offer row 7 (open row) while full: must not be stored
      step(OP_INS, 14'd7, 10'd0, 1'b0, 32'h0, '0);
      chk("R2 dropped while full hit_mask", 64'(hit_mask), 64'd0);
      chk("R2 still full", 64'(req_ready), 64'd0);

      // R9: age survives retire and refill
      step(OP_PRE, '0, '0, 1'b0, 32'h0, '0);
      chk("R3 oldest row", 64'(act_row), 64'd10);
      step(OP_ACT, '0, '0, 1'b0, 32'h0, '0);
      chk("R4 hit after act", 64'(hit_mask), 64'h01);
      step(OP_GNT, '0, '0, 1'b0, 32'h0, 3'd0);
      chk("R8 slot freed", 64'(req_ready), 64'd1);
      step(OP_PRE, '0, '0, 1'b0, 32'h0, '0);
      chk("R9 next oldest", 64'(act_row), 64'd11);
      step(OP_INS, 14'd30, 10'd0, 1'b0, 32'h0, '0);
      chk("R2 refill makes full", 64'(req_ready), 64'd0);
      chk("R9 refill younger", 64'(act_row), 64'd11);
      step(OP_ACT, '0, '0, 1'b0, 32'h0, '0);
      chk("R4 hit slot1", 64'(hit_mask), 64'h02);
      step(OP_GNT, '0, '0, 1'b0, 32'h0, 3'd1);
      step(OP_PRE, '0, '0, 1'b0, 32'h0, '0);
      chk("R7 closed", 64'(open_valid), 64'd0);
      chk("R7 no hits", 64'(hit_mask), 64'd0);
      chk("R9 third oldest", 64'(act_row), 64'd12);

      // R1: reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule